// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block is the reset generator of a small serial peripheral. It merges three sources of reset into one active-low output: power-up sequencing, brownout detection and a software watchdog. Two digital flags from outside comparators describe the supply. One says the supply is above the operating threshold. The other says it is above the lowest level at which the output can still be driven. The watchdog is serviced through the serial chip-select pin, which is shared with the serial port. Two period-select bits, kept in nonvolatile storage elsewhere, choose the timeout.

While reset is asserted the block raises a communication-inhibit flag so that the serial engine ignores traffic. On every entry into reset it emits a one-cycle abort pulse, which tells the engine to drop any transfer it has in progress. All times are expressed in milliseconds and scaled by the parameter `CYC_PER_MS`. A simulation can therefore use a small value and keep run times short.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_min_i` is low, all state is cleared asynchronously. `rst_n_o` is 0, `comm_inhibit_o` is 1 and `xfer_abort_o` is 0, and the chip-select synchroniser is preset to the idle level 1.
- R2: `rst_oe_o` is 1 exactly when `supply_min_i` is 1. The reset output is left undriven below the minimum supply.
- R3: If `supply_ok_i` is sampled low at a rising clock edge, `rst_n_o` is 0 after that edge. It stays 0 for as long as `supply_ok_i` stays low.
- R4: After reset is entered, `rst_n_o` returns to 1 only once `supply_ok_i` has been sampled high on 200*`CYC_PER_MS` consecutive edges while reset is held. A low sample restarts that count.
- R5: `comm_inhibit_o` is 1 exactly when `rst_n_o` is 0, whenever `supply_min_i` is 1.
- R6: `xfer_abort_o` is 1 for exactly the one cycle after the edge at which `rst_n_o` goes from 1 to 0, and is 0 at all other times.
- R7: The watchdog is serviced only by a 1-to-0 transition of `cs_wdi_ni`, seen after a two-flop synchroniser. A rising transition or a steady level does not restart the count.
- R8: `wd_sel_i` sets the timeout: 2'b00 = 1400 ms, 2'b01 = 600 ms, 2'b10 = 200 ms. If the timeout passes without a kick while reset is released, reset is asserted.
- R9: With `wd_sel_i` = 2'b11 the watchdog never asserts reset.
- R10: A watchdog timeout holds reset for the same 200 ms as a supply recovery, and then the watchdog count starts again from zero.
- R11: The watchdog count is held at zero while reset is asserted. Chip-select edges during reset have no effect on when the next timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| supply_min_i | input | 1 | Supply above minimum drive level; acts as the asynchronous clear when low |
| supply_ok_i | input | 1 | Supply above the trip threshold |
| cs_wdi_ni | input | 1 | Shared serial chip select and watchdog input, asynchronous |
| wd_sel_i | input | 2 | Watchdog period select |
| rst_n_o | output | 1 | Active-low reset |
| rst_oe_o | output | 1 | Output enable for the reset pin driver |
| comm_inhibit_o | output | 1 | Serial traffic must be ignored |
| xfer_abort_o | output | 1 | One-cycle pulse: abort the serial transfer in progress |

## Verification
On every cycle the assertions check four things. A low supply sample is followed by reset. Each release is preceded by exactly the full run of good-supply hold cycles. The abort pulse coincides one-for-one with reset falling. A disabled watchdog never causes a reset on its own. The bench scenarios are needed for the rest: the exact timeout length for each period code, the two-cycle synchroniser delay on kicks, the fact that rising edges and kicks during reset are ignored, and the restart of the count after a watchdog reset. A cycle-accurate reference model compares all four outputs against these scenarios on every clock.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        WD_1400MS = 2'b00,
        WD_600MS  = 2'b01,
        WD_200MS  = 2'b10,
        WD_OFF    = 2'b11
    } wd_sel_e;

    localparam int unsigned HOLD_MS = 200;

    function automatic int unsigned wd_period_ms(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1400;
            2'b01:   return 600;
            2'b10:   return 200;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic pin_i,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin_i};
        s_d.last  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fall_o = s_q.last & ~s_q.chain[STAGES-1];
endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog
    import rsv_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 1000,
    localparam int unsigned MAX_CYC   = 1400 * CYC_PER_MS,
    localparam int unsigned CW        = $clog2(MAX_CYC + 1)
) (
    input  logic       clk_i,
    input  logic       por_ni,
    input  logic       hold_i,
    input  logic [1:0] sel_i,
    input  logic       kick_i,
    output logic       expire_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t           w_d, w_q;
    logic [CW-1:0] last_idx;
    logic          enabled;

    always_comb begin
        last_idx = CW'(wd_period_ms(sel_i) * CYC_PER_MS - 1);
        enabled  = (sel_i != WD_OFF);
        expire_o = !hold_i && enabled && !kick_i && (w_q.cnt >= last_idx);
        w_d      = w_q;
        if (hold_i || !enabled || kick_i || expire_o) begin
            w_d.cnt = '0;
        end else begin
            w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end
endmodule

// File: rtl/rsv_hold.sv
module rsv_hold #(
    parameter int unsigned HOLD_CYC = 200000,
    localparam int unsigned CW      = $clog2(HOLD_CYC)
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic supply_ok_i,
    input  logic wd_expire_i,
    output logic rst_o,
    output logic abort_o
);
    typedef struct packed {
        logic          rst;
        logic          abort;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!supply_ok_i) begin
            h_d.rst = 1'b1;
            h_d.cnt = '0;
        end else if (h_q.rst) begin
            if (h_q.cnt == CW'(HOLD_CYC - 1)) begin
                h_d.rst = 1'b0;
                h_d.cnt = '0;
            end else begin
                h_d.cnt = h_q.cnt + 1'b1;
            end
        end else if (wd_expire_i) begin
            h_d.rst = 1'b1;
            h_d.cnt = '0;
        end
        h_d.abort = h_d.rst & ~h_q.rst;
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            h_q <= '{rst: 1'b1, abort: 1'b0, cnt: '0};
        end else begin
            h_q <= h_d;
        end
    end

    assign rst_o   = h_q.rst;
    assign abort_o = h_q.abort;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsv_pkg::*;
#(
    parameter int unsigned CYC_PER_MS  = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       supply_min_i,
    input  logic       supply_ok_i,
    input  logic       cs_wdi_ni,
    input  logic [1:0] wd_sel_i,
    output logic       rst_n_o,
    output logic       rst_oe_o,
    output logic       comm_inhibit_o,
    output logic       xfer_abort_o
);
    localparam int unsigned HOLD_CYC = HOLD_MS * CYC_PER_MS;

    logic kick;
    logic expire;
    logic in_rst;

    rsv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .por_ni (supply_min_i),
        .pin_i  (cs_wdi_ni),
        .fall_o (kick)
    );

    rsv_wdog #(.CYC_PER_MS(CYC_PER_MS)) u_wdog (
        .clk_i    (clk_i),
        .por_ni   (supply_min_i),
        .hold_i   (in_rst),
        .sel_i    (wd_sel_i),
        .kick_i   (kick),
        .expire_o (expire)
    );

    rsv_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk_i       (clk_i),
        .por_ni      (supply_min_i),
        .supply_ok_i (supply_ok_i),
        .wd_expire_i (expire),
        .rst_o       (in_rst),
        .abort_o     (xfer_abort_o)
    );

    assign rst_n_o        = ~in_rst;
    assign comm_inhibit_o = in_rst;
    assign rst_oe_o       = supply_min_i;
endmodule

// File: rtl/rsv_chk.sv
module rsv_chk #(
    parameter int unsigned CYC_PER_MS = 1000
) (
    input logic       clk_i,
    input logic       supply_min_i,
    input logic       supply_ok_i,
    input logic [1:0] wd_sel_i,
    input logic       rst_n_o,
    input logic       xfer_abort_o
);
    localparam int unsigned HOLD = 200 * CYC_PER_MS;

    int unsigned good_low;

    always_ff @(posedge clk_i or negedge supply_min_i) begin
        if (!supply_min_i) begin
            good_low <= 0;
        end else if (rst_n_o || !supply_ok_i) begin
            good_low <= 0;
        end else begin
            good_low <= good_low + 1;
        end
    end

    // R3
    brownout_rst_chk: assert property (@(posedge clk_i) disable iff (!supply_min_i)
        !supply_ok_i |=> !rst_n_o);

    // R4
    hold_len_chk: assert property (@(posedge clk_i) disable iff (!supply_min_i)
        $rose(rst_n_o) |-> (good_low == HOLD));

    // R6
    abort_on_entry_chk: assert property (@(posedge clk_i) disable iff (!supply_min_i)
        $fell(rst_n_o) |-> xfer_abort_o);

    // R6
    abort_only_entry_chk: assert property (@(posedge clk_i) disable iff (!supply_min_i)
        xfer_abort_o |-> $fell(rst_n_o));

    // R9
    wd_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!supply_min_i)
        ($fell(rst_n_o) && ($past(wd_sel_i) == 2'b11)) |-> !$past(supply_ok_i));
endmodule

bind rst_supervisor rsv_chk #(.CYC_PER_MS(CYC_PER_MS)) u_chk (
    .clk_i        (clk_i),
    .supply_min_i (supply_min_i),
    .supply_ok_i  (supply_ok_i),
    .wd_sel_i     (wd_sel_i),
    .rst_n_o      (rst_n_o),
    .xfer_abort_o (xfer_abort_o)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
    localparam int CYC = 2;
    localparam int HOLD = 200 * CYC;

    logic       clk = 1'b0;
    logic       smin = 1'b0;
    logic       ok = 1'b0;
    logic       pin = 1'b1;
    logic [1:0] sel = 2'b10;
    logic       rst_n, oe, inh, abrt;

    int    vectors = 0;
    int    miscompares = 0;
    string cur = "R1";

    always #4 clk = ~clk;

    rst_supervisor #(.CYC_PER_MS(CYC)) dut (
        .clk_i(clk), .supply_min_i(smin), .supply_ok_i(ok), .cs_wdi_ni(pin),
        .wd_sel_i(sel), .rst_n_o(rst_n), .rst_oe_o(oe),
        .comm_inhibit_o(inh), .xfer_abort_o(abrt)
    );

    // behavioural reference
    bit m_s1 = 1, m_s2 = 1, m_prev = 1, m_rst = 1, m_abort = 0;
    int m_hold = 0, m_wd = 0;

    function automatic int limit(input logic [1:0] s);
        if (s == 2'b00) return 1400 * CYC;
        if (s == 2'b01) return 600 * CYC;
        if (s == 2'b10) return 200 * CYC;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!smin) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_rst = 1; m_abort = 0; m_hold = 0; m_wd = 0;
        end else begin
            bit kicked, timed_out, was_rst;
            kicked    = m_prev && !m_s2;
            timed_out = !m_rst && (limit(sel) > 0) && !kicked && (m_wd >= limit(sel) - 1);
            was_rst   = m_rst;
            if (m_rst || limit(sel) < 0 || kicked || timed_out) m_wd = 0;
            else m_wd++;
            if (!ok) begin
                m_rst = 1; m_hold = 0;
            end else if (m_rst) begin
                if (m_hold == HOLD - 1) begin m_rst = 0; m_hold = 0; end
                else m_hold++;
            end else if (timed_out) begin
                m_rst = 1; m_hold = 0;
            end
            m_abort = m_rst && !was_rst;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check("R2", "rst_oe", oe, smin);
        check(cur, "rst_n", rst_n, smin ? !m_rst : 1'b0);
        check("R5", "comm_inhibit", inh, smin ? m_rst : 1'b1);
        check("R6", "xfer_abort", abrt, smin ? m_abort : 1'b0);
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic kick();
        pin = 1'b0; cycles(3);
        pin = 1'b1; cycles(3);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired R1 actual=running expected=done");
        finish_run();
    end

    initial begin
        cycles(10);                       // R1: held below minimum supply
        smin = 1'b1; cur = "R3"; cycles(20);
        ok = 1'b1; cur = "R4"; cycles(HOLD + 20);
        cur = "R7";                       // R7 R8: 200 ms period kept alive
        for (int i = 0; i < 4; i++) begin cycles(300); kick(); end
        pin = 1'b0; cycles(3);            // falling edge kicks
        cycles(250); pin = 1'b1;          // rising edge must not kick
        cycles(200);                      // timeout lands here
        cur = "R11";
        for (int i = 0; i < 3; i++) begin cycles(60); kick(); end
        cycles(HOLD);
        cur = "R10"; cycles(HOLD + HOLD + 40);
        cur = "R9"; sel = 2'b11; cycles(HOLD + 3000);
        cur = "R8"; sel = 2'b01; cycles(1300);
        cycles(HOLD + 10);
        sel = 2'b00;
        for (int i = 0; i < 2; i++) begin cycles(2000); kick(); end
        cycles(2900 + HOLD);
        cur = "R6"; pin = 1'b0; cycles(50);
        cur = "R3"; ok = 1'b0; cycles(6);
        ok = 1'b1; cycles(3); ok = 1'b0; cycles(2); ok = 1'b1;
        pin = 1'b1; cur = "R4"; cycles(HOLD + 10);
        cur = "R1"; smin = 1'b0; cycles(5);
        smin = 1'b1; cycles(HOLD + 10);
        finish_run();
    end
endmodule